// File: doc/BRIEF.md
# Time-Slotted Shared Hitmap Decode Arbiter

This block lets a group of parallel decode engines share one two-port hitmap lookup resource, so that no engine needs a private copy. Each engine owns a mailbox. It posts an encoded word into the mailbox. Some cycles later it receives the decoded word back in the same mailbox, flagged by a one-cycle valid pulse.

Access to the shared lookup does not depend on contention. A free-running frame counter cycles through six slots, which matches the six-cycle period in which an engine handles one quarter row. Each engine owns exactly one slot on one of the two lookup ports. Port A serves engines 0 to 5 and port B serves engines 6 to 11, so two engines can be served in the same cycle. Every engine is therefore guaranteed a bounded wait and a fixed lookup latency.

The shared lookup is modelled as a pipelined function with `PIPE_DEPTH` register stages. The decoded word is the bit-reversed encoded word.

Top module: `shdec_slot_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, every mailbox reports empty (`req_pending` all zero) and `rsp_valid` is all zero.
- R2: A frame counter is 0 in the first cycle after reset. It advances by one each cycle and returns to 0 after 5, giving a frame of six cycles.
- R3: In frame slot s, port A may issue the request of engine s and port B that of engine s+6. Both may issue in the same cycle, and no engine issues in any other slot.
- R4: A cycle with `req_valid[e]` high stores `req_word[e]` in mailbox e and raises `req_pending[e]` from the next cycle. The word is held until the first cycle whose slot belongs to engine e, where it is issued and the pending flag drops.
- R5: A post to a mailbox that is already pending and is not issuing in that cycle is ignored. The earlier word is the one decoded.
- R6: A word issued at clock edge E produces `rsp_valid[e]` high for exactly one cycle, the cycle after edge E+`PIPE_DEPTH`. In that cycle `rsp_word[e]` holds the encoded word bit-reversed (result bit i = request bit 15-i).
- R7: While `eng_en[e]` is low, engine e's slot stays idle and its pending word is held. Issue resumes at the engine's first slot after `eng_en[e]` returns high.
- R8: A post in the same cycle that the mailbox issues is accepted. The new word becomes pending and is issued one frame later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_en | input | NUM_ENG | Per-engine enable; a disabled engine's slot is idle |
| req_valid | input | NUM_ENG | Per-engine post strobe |
| req_word | input | NUM_ENG*16 | Encoded word per engine, engine e at bits [16e+15:16e] |
| req_pending | output | NUM_ENG | Mailbox holds a word waiting for its slot |
| rsp_valid | output | NUM_ENG | One-cycle result pulse per engine |
| rsp_word | output | NUM_ENG*16 | Decoded word per engine, engine e at bits [16e+15:16e] |

## Verification
Several properties are checked by assertions on every cycle:
- the frame counter steps by one and wraps;
- an untaken mailbox keeps both its flag and its word;
- a post into a busy mailbox does not alter the stored word;
- a refill at the issuing edge stays pending;
- a disabled engine never issues;
- the two ports never target the same engine;
- each result is a single-cycle pulse.

The exact issue slot, the latency of `PIPE_DEPTH` cycles and the decoded values are only visible by comparing against the bench's cycle model. The same holds for resumption after re-enable, simultaneous issue on both ports, and the full-load case where all twelve engines post together.

// File: rtl/shdec_pkg.sv
package shdec_pkg;

    localparam int FRAME_LEN   = 6;
    localparam int N_PORTS     = 2;
    localparam int MAX_ENGINES = FRAME_LEN * N_PORTS;
    localparam int HMAP_W      = 16;
    localparam int ENG_IDX_W   = $clog2(MAX_ENGINES);
    localparam int SLOT_W      = $clog2(FRAME_LEN);

    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [ENG_IDX_W-1:0] eng_idx_t;
    typedef logic [HMAP_W-1:0]    hmap_t;

    // One transfer on a lookup port: request going in or result coming out
    typedef struct packed {
        logic     vld;
        eng_idx_t eng;
        hmap_t    word;
    } beat_t;

    // Shared lookup function: bit-reversal of the encoded word
    function automatic hmap_t decode_word(hmap_t enc);
        hmap_t r;
        for (int i = 0; i < HMAP_W; i++) begin
            r[i] = enc[HMAP_W-1-i];
        end
        return r;
    endfunction

    function automatic slot_t slot_of(int e);
        return slot_t'(e % FRAME_LEN);
    endfunction

    function automatic int port_of(int e);
        return e / FRAME_LEN;
    endfunction

endpackage

// File: rtl/shdec_slot_timer.sv
module shdec_slot_timer
    import shdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_t slot_q
);

    localparam slot_t LAST_SLOT = slot_t'(FRAME_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + slot_t'(1);
        end
    end

    // R2: wrap from the last slot to zero
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        slot_q == LAST_SLOT |=> slot_q == '0);

    // R2: step by one inside the frame
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        slot_q != LAST_SLOT |=> slot_q == $past(slot_q) + slot_t'(1));

endmodule

// File: rtl/shdec_mailbox.sv
module shdec_mailbox
    import shdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  post,
    input  hmap_t post_word,
    input  logic  take,
    output logic  pend_q,
    output hmap_t word_q
);

    logic accept;

    assign accept = post && (!pend_q || take);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            word_q <= '0;
        end else if (accept) begin
            pend_q <= 1'b1;
            word_q <= post_word;
        end else if (take) begin
            pend_q <= 1'b0;
        end
    end

    // R4: a pending word not taken stays pending and unchanged
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        pend_q && !take |=> pend_q && $stable(word_q));

    // R5: a post into a busy, non-issuing mailbox leaves the word alone
    a_r5_drop: assert property (@(posedge clk) disable iff (rst)
        pend_q && !take && post |=> word_q == $past(word_q));

    // R8: refill on the issuing edge stays pending
    a_r8_refill: assert property (@(posedge clk) disable iff (rst)
        take && post |=> pend_q);

    // R4: issue only ever drains a pending mailbox
    a_r4_take_pending: assert property (@(posedge clk) disable iff (rst)
        take |-> pend_q);

endmodule

// File: rtl/shdec_lookup_pipe.sv
module shdec_lookup_pipe
    import shdec_pkg::*;
#(
    parameter int PIPE_DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t issue_i,
    output beat_t result_o
);

    beat_t stage_q [PIPE_DEPTH];
    beat_t first_beat;

    always_comb begin
        first_beat      = issue_i;
        first_beat.word = decode_word(issue_i.word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int st = 0; st < PIPE_DEPTH; st++) begin
                stage_q[st] <= '0;
            end
        end else begin
            stage_q[0] <= first_beat;
            for (int st = 1; st < PIPE_DEPTH; st++) begin
                stage_q[st] <= stage_q[st-1];
            end
        end
    end

    assign result_o = stage_q[PIPE_DEPTH-1];

    // R6: the first stage captures every issue
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        issue_i.vld |=> stage_q[0].vld && stage_q[0].eng == $past(issue_i.eng));

endmodule

// File: rtl/shdec_result_router.sv
module shdec_result_router
    import shdec_pkg::*;
#(
    parameter int NUM_ENG = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  beat_t              port_res [N_PORTS],
    output logic [NUM_ENG-1:0] rsp_valid_q,
    output hmap_t              rsp_word_q [NUM_ENG]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= '0;
            for (int e = 0; e < NUM_ENG; e++) begin
                rsp_word_q[e] <= '0;
            end
        end else begin
            rsp_valid_q <= '0;
            for (int p = 0; p < N_PORTS; p++) begin
                if (port_res[p].vld && int'(port_res[p].eng) < NUM_ENG) begin
                    rsp_valid_q[port_res[p].eng] <= 1'b1;
                    rsp_word_q[port_res[p].eng]  <= port_res[p].word;
                end
            end
        end
    end

    // R3: the two ports never carry the same engine at once
    a_r3_ports_distinct: assert property (@(posedge clk) disable iff (rst)
        port_res[0].vld && port_res[1].vld |-> port_res[0].eng != port_res[1].eng);

    generate
        for (genvar e = 0; e < NUM_ENG; e++) begin : g_pulse
            // R6: a result is a one-cycle pulse
            a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
                rsp_valid_q[e] |=> !rsp_valid_q[e]);
        end
    endgenerate

endmodule

// File: rtl/shdec_slot_arbiter.sv
module shdec_slot_arbiter
    import shdec_pkg::*;
#(
    parameter int NUM_ENG    = 12,
    parameter int PIPE_DEPTH = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_ENG-1:0]        eng_en,
    input  logic [NUM_ENG-1:0]        req_valid,
    input  logic [NUM_ENG*HMAP_W-1:0] req_word,
    output logic [NUM_ENG-1:0]        req_pending,
    output logic [NUM_ENG-1:0]        rsp_valid,
    output logic [NUM_ENG*HMAP_W-1:0] rsp_word
);

    slot_t              slot_q;
    logic [NUM_ENG-1:0] pend;
    logic [NUM_ENG-1:0] take;
    hmap_t              mbox_word [NUM_ENG];
    hmap_t              out_word  [NUM_ENG];
    beat_t              port_issue [N_PORTS];
    beat_t              port_res   [N_PORTS];

    shdec_slot_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .slot_q (slot_q)
    );

    // Static slot ownership: each port picks the one engine owning this slot
    always_comb begin
        for (int p = 0; p < N_PORTS; p++) begin
            port_issue[p] = '0;
            for (int e = 0; e < NUM_ENG; e++) begin
                if (port_of(e) == p && slot_of(e) == slot_q && pend[e] && eng_en[e]) begin
                    port_issue[p].vld  = 1'b1;
                    port_issue[p].eng  = eng_idx_t'(e);
                    port_issue[p].word = mbox_word[e];
                end
            end
        end
    end

    generate
        for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
            localparam int PE = e / FRAME_LEN;

            assign take[e] = port_issue[PE].vld && (port_issue[PE].eng == eng_idx_t'(e));

            shdec_mailbox u_mbox (
                .clk       (clk),
                .rst       (rst),
                .post      (req_valid[e]),
                .post_word (req_word[e*HMAP_W +: HMAP_W]),
                .take      (take[e]),
                .pend_q    (pend[e]),
                .word_q    (mbox_word[e])
            );

            assign rsp_word[e*HMAP_W +: HMAP_W] = out_word[e];

            // R7: a disabled engine never issues
            a_r7_disabled_idle: assert property (@(posedge clk) disable iff (rst)
                !eng_en[e] |-> !take[e]);
        end

        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            shdec_lookup_pipe #(
                .PIPE_DEPTH (PIPE_DEPTH)
            ) u_pipe (
                .clk      (clk),
                .rst      (rst),
                .issue_i  (port_issue[p]),
                .result_o (port_res[p])
            );
        end
    endgenerate

    shdec_result_router #(
        .NUM_ENG (NUM_ENG)
    ) u_router (
        .clk         (clk),
        .rst         (rst),
        .port_res    (port_res),
        .rsp_valid_q (rsp_valid),
        .rsp_word_q  (out_word)
    );

    assign req_pending = pend;

    // R3: at most one issue per port per cycle
    a_r3_two_per_cycle: assert property (@(posedge clk) disable iff (rst)
        $countones(take) <= N_PORTS);

endmodule

// File: tb/shdec_slot_arbiter_tb.sv
module shdec_slot_arbiter_tb_top;

    localparam int NE   = 12;
    localparam int PIPE = 3;
    localparam int W    = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NE-1:0]   eng_en = '1;
    logic [NE-1:0]   req_valid = '0;
    logic [NE*W-1:0] req_word = '0;
    logic [NE-1:0]   req_pending;
    logic [NE-1:0]   rsp_valid;
    logic [NE*W-1:0] rsp_word;

    always #10 clk = ~clk;

    shdec_slot_arbiter #(.NUM_ENG(NE), .PIPE_DEPTH(PIPE)) dut_i (
        .clk (clk), .rst (rst), .eng_en (eng_en), .req_valid (req_valid),
        .req_word (req_word), .req_pending (req_pending),
        .rsp_valid (rsp_valid), .rsp_word (rsp_word)
    );

    int    checks = 0;
    int    errors = 0;
    bit    started = 0;
    bit    done = 0;
    string tag = "R1";

    // Behavioural reference state
    int          m_slot;
    bit          m_pend [NE];
    logic [15:0] m_box  [NE];
    int          m_cnt  [NE];
    logic [15:0] m_res  [NE];
    bit          m_rv   [NE];
    logic [15:0] m_rd   [NE];

    function automatic logic [15:0] reverse16(logic [15:0] x);
        logic [15:0] acc = '0;
        for (int i = 0; i < 16; i++) acc = (acc << 1) | 16'((x >> i) & 16'h1);
        return acc;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_slot = 0;
            for (int e = 0; e < NE; e++) begin
                m_pend[e] = 0; m_cnt[e] = 0; m_rv[e] = 0; m_box[e] = '0;
            end
        end else begin
            for (int e = 0; e < NE; e++) begin
                m_rv[e] = 0;
                if (m_cnt[e] > 0) begin
                    m_cnt[e]--;
                    if (m_cnt[e] == 0) begin m_rv[e] = 1; m_rd[e] = m_res[e]; end
                end
            end
            for (int e = 0; e < NE; e++) begin
                bit iss;
                iss = m_pend[e] && eng_en[e] && (e % 6 == m_slot);
                if (iss) begin m_cnt[e] = PIPE; m_res[e] = reverse16(m_box[e]); end
                if (req_valid[e] && (!m_pend[e] || iss)) begin
                    m_pend[e] = 1; m_box[e] = req_word[e*W +: W];
                end else if (iss) begin
                    m_pend[e] = 0;
                end
            end
            m_slot = (m_slot + 1) % 6;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            for (int e = 0; e < NE; e++) begin
                checks++;
                if (rsp_valid[e] !== m_rv[e]) begin
                    errors++;
                    $display("FAIL %s: rsp_valid[%0d] actual %b expected %b", tag, e, rsp_valid[e], m_rv[e]);
                end
                checks++;
                if (req_pending[e] !== m_pend[e]) begin
                    errors++;
                    $display("FAIL %s: req_pending[%0d] actual %b expected %b", tag, e, req_pending[e], m_pend[e]);
                end
                if (m_rv[e]) begin
                    checks++;
                    if (rsp_word[e*W +: W] !== m_rd[e]) begin
                        errors++;
                        $display("FAIL %s: rsp_word[%0d] actual %h expected %h", tag, e, rsp_word[e*W +: W], m_rd[e]);
                    end
                end
            end
        end
    end

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic post(int e, logic [15:0] w);
        req_valid[e] = 1'b1;
        req_word[e*W +: W] = w;
        @(negedge clk);
        req_valid[e] = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        // R1: reset state and the cycle after reset
        wait_cycles(3);
        rst = 1'b0;
        wait_cycles(2);

        // R2 / R4 / R6: single posts and latency against the frame counter
        tag = "R6";
        post(0, 16'h8001);
        wait_cycles(10);
        post(7, 16'h00F3);
        wait_cycles(10);

        // R3: every engine posts at once, both ports busy in each slot
        tag = "R3";
        for (int e = 0; e < NE; e++) begin
            req_valid[e] = 1'b1;
            req_word[e*W +: W] = 16'(16'h1234 * (e + 1));
        end
        @(negedge clk);
        req_valid = '0;
        wait_cycles(14);

        // R5: second post into a busy mailbox is dropped
        tag = "R5";
        while (m_slot != 4) @(negedge clk);
        post(3, 16'hA5C3);
        post(3, 16'h0F0F);
        wait_cycles(12);

        // R7: disabled engine holds its word, then resumes
        tag = "R7";
        eng_en[5] = 1'b0;
        post(5, 16'h6E21);
        wait_cycles(15);
        eng_en[5] = 1'b1;
        wait_cycles(10);

        // R8: post landing on the issuing edge
        tag = "R8";
        post(2, 16'h1357);
        while (!(m_pend[2] && m_slot == 2)) @(negedge clk);
        post(2, 16'hBEEF);
        wait_cycles(14);

        // R4: mixed random traffic with enables toggling
        tag = "R4";
        for (int c = 0; c < 400; c++) begin
            req_valid = NE'($urandom);
            for (int e = 0; e < NE; e++) req_word[e*W +: W] = 16'($urandom);
            if (c % 37 == 0) eng_en = NE'($urandom) | NE'(12'h0F0);
            @(negedge clk);
        end
        req_valid = '0;
        eng_en = '1;
        wait_cycles(20);

        finish_run();
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule